// File: doc/BRIEF.md
# Generation-Bit Completion Queue Poller

This block hands completion entries to a consumer from two sources. The main source is a power-of-two ring of entries held in local storage. A producer fills the ring slot by slot. Each entry carries a generation bit, and the poller uses that bit to decide whether the slot holds a fresh completion or one left over from the previous lap. The second source is a small overflow ring that software fills. Whenever the overflow ring holds anything, its oldest entry is presented first.

Each entry is a 32-bit header plus a data word. The block splits the header of the chosen entry into its fields and offers the entry on a valid/ready output. When the consumer takes the entry, the read pointer of the source that supplied it moves on by one. Read pointers run free and are one bit wider than the slot index, so the top bit tells which lap the pointer is on. The block also keeps a sticky queue-error status, stored in the slot just past the last ring entry.

Top module: `cq_poller`

## Requirements
- R1: After a synchronous active-high reset: out_valid is 0, in_error is 0, sw_count is 0, sw_free equals 2^SW_LOG2, and every ring slot holds generation bit 0.
- R2: A ring entry is presented only when its header generation bit (bit 10) equals the inverse of bit [HW_LOG2] of the ring read pointer. An entry left from the previous lap, or one whose generation bit does not match, is never delivered.
- R3: While the overflow ring is not empty, its entry at the overflow read index is presented with out_from_sw = 1, whatever the main ring holds.
- R4: The header is decoded as: bit 31 out-of-order flag, bits 30:12 queue-pair id, bit 11 software-made flag, bit 10 generation, bits 9:5 status, bit 4 type, bits 3:0 opcode. out_header and out_data carry the chosen entry unchanged (entry bits 31:0 are the header, the upper bits are the data).
- R5: out_is_sq is 1 for type 1 (send-queue completion) and 0 for type 0 (receive-queue completion).
- R6: out_send_op is 1 exactly when the opcode is 3, 4, 5 or 6.
- R7: When out_valid and out_ready are both 1, only the read pointer of the source that supplied the entry advances, by one. Main-ring slots are consumed in index order and wrap after slot 2^HW_LOG2-1.
- R8: sw_count is the overflow write pointer minus its read pointer, and sw_free is 2^SW_LOG2 minus sw_count. sw_full is 1 when that difference has bit SW_LOG2 set. A push while sw_full is ignored.
- R9: set_error writes 1 into the status slot, and in_error then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prod_we | input | 1 | Producer writes one ring slot |
| prod_idx | input | HW_LOG2 | Slot index written by the producer |
| prod_entry | input | 32+DATA_W | Entry written by the producer |
| sw_push | input | 1 | Push one entry into the overflow ring |
| sw_entry | input | 32+DATA_W | Entry pushed into the overflow ring |
| sw_count | output | SW_LOG2+1 | Overflow ring occupancy |
| sw_free | output | SW_LOG2+1 | Free overflow slots |
| sw_full | output | 1 | Overflow ring full |
| set_error | input | 1 | Write 1 into the error status slot |
| in_error | output | 1 | Sticky queue-error status |
| out_ready | input | 1 | Consumer takes the presented entry |
| out_valid | output | 1 | An entry is presented |
| out_from_sw | output | 1 | Presented entry comes from the overflow ring |
| out_header | output | 32 | Raw header of the presented entry |
| out_data | output | DATA_W | Data word of the presented entry |
| out_ooo | output | 1 | Out-of-order flag |
| out_qpid | output | 19 | Queue-pair id |
| out_sw_made | output | 1 | Software-made flag |
| out_gen | output | 1 | Generation bit |
| out_status | output | 5 | Status code |
| out_is_sq | output | 1 | Send-queue completion |
| out_opcode | output | 4 | Opcode |
| out_send_op | output | 1 | Opcode is one of the send variants |

## Verification
The bench builds the block with HW_LOG2 = 3 and SW_LOG2 = 2. With 8 ring slots, 24 completions take the read pointer through three laps, so both expected generation values are used and every slot first holds a stale entry before it is refilled. With 4 overflow slots, only a few pushes are needed to reach the full state and test that an extra push is dropped. These runs sit alongside a sweep of all 16 opcodes and random header fields.

// File: rtl/cq_poller.sv
module cq_poller #(
  parameter int HW_LOG2 = 4,
  parameter int SW_LOG2 = 2,
  parameter int DATA_W  = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  prod_we,
  input  logic [HW_LOG2-1:0]    prod_idx,
  input  logic [32+DATA_W-1:0]  prod_entry,
  input  logic                  sw_push,
  input  logic [32+DATA_W-1:0]  sw_entry,
  output logic [SW_LOG2:0]      sw_count,
  output logic [SW_LOG2:0]      sw_free,
  output logic                  sw_full,
  input  logic                  set_error,
  output logic                  in_error,
  input  logic                  out_ready,
  output logic                  out_valid,
  output logic                  out_from_sw,
  output logic [31:0]           out_header,
  output logic [DATA_W-1:0]     out_data,
  output logic                  out_ooo,
  output logic [18:0]           out_qpid,
  output logic                  out_sw_made,
  output logic                  out_gen,
  output logic [4:0]            out_status,
  output logic                  out_is_sq,
  output logic [3:0]            out_opcode,
  output logic                  out_send_op
);
  localparam int HW_N  = 1 << HW_LOG2;
  localparam int SW_N  = 1 << SW_LOG2;
  localparam int ENT_W = 32 + DATA_W;

  logic [ENT_W-1:0] hw_ring [HW_N];
  logic [ENT_W-1:0] sw_ring [SW_N];
  logic             status_slot;
  logic [HW_LOG2:0] hw_rptr;
  logic [SW_LOG2:0] sw_rptr, sw_wptr;

  logic [ENT_W-1:0] hw_head, pick;
  logic             sw_empty, hw_fresh, take;

  assign sw_count = sw_wptr - sw_rptr;
  assign sw_free  = (SW_LOG2+1)'(SW_N) - sw_count;
  assign sw_empty = (sw_wptr == sw_rptr);
  assign sw_full  = ((sw_count >> SW_LOG2) != '0) && !sw_empty;

  assign hw_head  = hw_ring[hw_rptr[HW_LOG2-1:0]];
  assign hw_fresh = (hw_head[10] == ~hw_rptr[HW_LOG2]);
  assign pick     = sw_empty ? hw_head : sw_ring[sw_rptr[SW_LOG2-1:0]];

  assign out_from_sw = !sw_empty;
  assign out_valid   = !sw_empty || hw_fresh;
  assign take        = out_valid && out_ready;
  assign in_error    = status_slot;

  assign out_header  = pick[31:0];
  assign out_data    = pick[ENT_W-1:32];
  assign out_ooo     = pick[31];
  assign out_qpid    = pick[30:12];
  assign out_sw_made = pick[11];
  assign out_gen     = pick[10];
  assign out_status  = pick[9:5];
  assign out_is_sq   = pick[4];
  assign out_opcode  = pick[3:0];
  assign out_send_op = (pick[3:0] >= 4'd3) && (pick[3:0] <= 4'd6);

  always_ff @(posedge clk) begin
    if (rst) begin
      hw_rptr     <= '0;
      sw_rptr     <= '0;
      sw_wptr     <= '0;
      status_slot <= 1'b0;
      for (int i = 0; i < HW_N; i++) hw_ring[i] <= '0;
    end else begin
      if (prod_we) hw_ring[prod_idx] <= prod_entry;
      if (sw_push && !sw_full) sw_wptr <= sw_wptr + 1'b1;
      if (take) begin
        if (!sw_empty) sw_rptr <= sw_rptr + 1'b1;
        else           hw_rptr <= hw_rptr + 1'b1;
      end
      if (set_error) status_slot <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && sw_push && !sw_full) sw_ring[sw_wptr[SW_LOG2-1:0]] <= sw_entry;
  end
endmodule

// File: rtl/cq_poller_chk.sv
module cq_poller_chk #(
  parameter int HW_LOG2 = 4,
  parameter int SW_LOG2 = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               out_valid,
  input logic               out_ready,
  input logic               out_from_sw,
  input logic               out_gen,
  input logic               in_error,
  input logic               sw_push,
  input logic [SW_LOG2:0]   sw_count,
  input logic [HW_LOG2:0]   hw_rptr,
  input logic [SW_LOG2:0]   sw_rptr
);
  localparam int SW_N = 1 << SW_LOG2;

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !in_error && sw_count == '0));

  a_r2_gen_match: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_from_sw) |-> (out_gen != hw_rptr[HW_LOG2]));

  a_r3_sw_first: assert property (@(posedge clk) disable iff (rst)
    (sw_count != '0) |-> (out_valid && out_from_sw));

  a_r7_hw_step: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !out_from_sw) |=>
      (hw_rptr == (HW_LOG2+1)'($past(hw_rptr) + 1'b1)) && (sw_rptr == $past(sw_rptr)));

  a_r7_sw_step: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_from_sw) |=>
      (sw_rptr == (SW_LOG2+1)'($past(sw_rptr) + 1'b1)) && $stable(hw_rptr));

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    ((sw_count == (SW_LOG2+1)'(SW_N)) && sw_push && !(out_ready && out_from_sw)) |=>
      (sw_count == (SW_LOG2+1)'(SW_N)));

  a_r9_sticky_error: assert property (@(posedge clk) disable iff (rst)
    in_error |=> in_error);
endmodule

bind cq_poller cq_poller_chk #(.HW_LOG2(HW_LOG2), .SW_LOG2(SW_LOG2)) u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
  .out_from_sw(out_from_sw), .out_gen(out_gen), .in_error(in_error),
  .sw_push(sw_push), .sw_count(sw_count), .hw_rptr(hw_rptr), .sw_rptr(sw_rptr)
);

// File: tb/cq_poller_bench.sv
`timescale 1ns/1ps
module cq_poller_bench;
  localparam int HL = 3, SL = 2, DW = 32;
  localparam int HN = 1 << HL, SN = 1 << SL;

  logic clk = 0, rst = 1;
  logic prod_we = 0, sw_push = 0, set_error = 0, out_ready = 0;
  logic [HL-1:0] prod_idx = '0;
  logic [63:0] prod_entry = '0, sw_entry = '0;
  logic [SL:0] sw_count, sw_free;
  logic sw_full, in_error, out_valid, out_from_sw, out_ooo, out_sw_made, out_gen, out_is_sq, out_send_op;
  logic [31:0] out_header;
  logic [DW-1:0] out_data;
  logic [18:0] out_qpid;
  logic [4:0] out_status;
  logic [3:0] out_opcode;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  cq_poller #(.HW_LOG2(HL), .SW_LOG2(SL), .DATA_W(DW)) u_cq_poller (.*);

  function automatic logic [31:0] mk_hdr(logic ooo, logic [18:0] qp, logic swm, logic g,
                                         logic [4:0] st, logic ty, logic [3:0] op);
    return {ooo, qp, swm, g, st, ty, op};
  endfunction

  function automatic logic is_send(logic [3:0] op);
    return op == 4'd3 || op == 4'd4 || op == 4'd5 || op == 4'd6;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic chk_fields(string tag, logic ooo, logic [18:0] qp, logic swm, logic g,
                            logic [4:0] st, logic ty, logic [3:0] op, logic [31:0] d, logic from_sw);
    chk({tag, " R4 header"}, out_header, mk_hdr(ooo, qp, swm, g, st, ty, op));
    chk({tag, " R4 data"}, out_data, d);
    chk({tag, " R4 fields"}, {out_ooo, out_qpid, out_sw_made, out_gen, out_status, out_opcode},
        {ooo, qp, swm, g, st, op});
    chk({tag, " R5 type"}, out_is_sq, ty);
    chk({tag, " R6 send"}, out_send_op, is_send(op));
    chk({tag, " R3 source"}, out_from_sw, from_sw);
  endtask

  task automatic pop;
    out_ready = 1; tick; out_ready = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic ooo, swm, ty, g;
    logic [18:0] qp;
    logic [4:0] st;
    logic [3:0] op;
    logic [31:0] d;
    void'($urandom(32'h5eed_c0de));
    repeat (3) tick;
    rst = 0;
    chk("R1 valid", out_valid, 0);
    chk("R1 error", in_error, 0);
    chk("R1 count", sw_count, 0);
    chk("R1 free", sw_free, SN);
    chk("R1 full", sw_full, 0);

    for (int lap = 0; lap < 3; lap++) begin
      for (int i = 0; i < HN; i++) begin
        chk("R2 stale slot not delivered", out_valid, 0);
        ooo = 1'($urandom); swm = 1'($urandom); ty = 1'($urandom);
        qp = 19'($urandom); st = 5'($urandom); op = 4'($urandom); d = $urandom;
        g = ~lap[0];
        prod_we = 1; prod_idx = HL'(i); prod_entry = {d, mk_hdr(ooo, qp, swm, g, st, ty, op)};
        tick; prod_we = 0;
        chk("R2 fresh entry valid", out_valid, 1);
        chk_fields("R7 lap", ooo, qp, swm, g, st, ty, op, d, 0);
        pop();
      end
    end
    chk("R7 ring drained after wraps", out_valid, 0);

    // read pointer on lap 3 expects generation 0; a gen-1 entry is stale
    prod_we = 1; prod_idx = 0; prod_entry = {32'h1234, mk_hdr(0, 19'h5, 0, 1, 0, 1, 4'd3)};
    tick; prod_we = 0;
    chk("R2 mismatched gen rejected", out_valid, 0);
    prod_we = 1; prod_entry = {32'hABCD, mk_hdr(1, 19'h7_1234, 0, 0, 5'h1F, 0, 4'd9)};
    tick; prod_we = 0;
    chk("R2 matched gen accepted", out_valid, 1);

    for (int k = 0; k < SN + 1; k++) begin
      sw_push = 1; sw_entry = {32'(k + 100), mk_hdr(0, 19'(k), 1, 0, 5'(k), 1, 4'(k + 2))};
      tick; sw_push = 0;
    end
    chk("R8 count at full", sw_count, SN);
    chk("R8 free at full", sw_free, 0);
    chk("R8 full flag", sw_full, 1);
    for (int k = 0; k < SN; k++) begin
      chk_fields("R3 overflow first", 0, 19'(k), 1, 0, 5'(k), 1, 4'(k + 2), 32'(k + 100), 1);
      pop();
      chk("R8 count after pop", sw_count, SN - 1 - k);
    end
    chk("R8 extra push dropped", out_from_sw, 0);
    chk_fields("R7 ring entry kept", 1, 19'h7_1234, 0, 0, 5'h1F, 0, 4'd9, 32'hABCD, 0);
    pop();
    chk("R7 ring empty again", out_valid, 0);

    for (int k = 0; k < 16; k++) begin
      ty = 1'($urandom); qp = 19'($urandom); st = 5'($urandom); d = $urandom;
      sw_push = 1; sw_entry = {d, mk_hdr(0, qp, 1, 1, st, ty, 4'(k))};
      tick; sw_push = 0;
      chk_fields("R6 opcode sweep", 0, qp, 1, 1, st, ty, 4'(k), d, 1);
      pop();
    end

    chk("R9 error clear", in_error, 0);
    set_error = 1; tick; set_error = 0;
    chk("R9 error set", in_error, 1);
    repeat (5) tick;
    chk("R9 error sticky", in_error, 1);
    rst = 1; tick; rst = 0;
    chk("R1 error after reset", in_error, 0);
    chk("R1 valid after reset", out_valid, 0);
    summary();
  end
endmodule